// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block drives one DMA channel. It walks a list of linked descriptors and produces, for each element, a source address, a destination address and the transfer width. It does not move any data. When the channel is enabled, it reads a six-word descriptor through a memory read port that uses valid/ready. It then steps through a nested loop: an inner row of X elements, repeated Y times. Each element is offered as a request on a valid/ready transfer port. When a descriptor finishes, the block follows that descriptor's link word to the next one. Otherwise it either turns the channel off or starts over from the head descriptor.

An input trigger starts work. A control field in each descriptor sets how much work one trigger allows: a single element, one row, the whole descriptor, or the whole linked chain. A trigger that arrives while the block is busy is kept in a one-deep pending flag. As an option, the block can refuse a new trigger until the trigger input has dropped low. Two further fields choose which event (element, row, descriptor or chain) produces the interrupt pulse and which produces the trigger-out pulse.

Back-pressure rules: while a read request is valid and not ready, the request and its address are held. The block keeps one read outstanding and always accepts the response. While a transfer request is valid and not ready, the request, both addresses and the size fields are held. The element counts as done only on the cycle where valid and ready are both high.

Top module: `dma2d_seq`

## Requirements
- R1: After reset the channel is disabled. No read request, no transfer request, no interrupt pulse and no trigger-out pulse is active.
- R2: A pulse on `en_set_i` while the channel is disabled enables it. The block then reads the six descriptor words in order, at the given pointer plus 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14. A pulse on `en_set_i` while the channel is enabled is ignored.
- R3: The word order is: control, source, destination, X control, Y control, link. In the X control word, bits 7:0 hold the X count minus one, bits 19:8 hold the signed source X step and bits 31:20 hold the signed destination X step. The Y control word uses the same layout for the Y count and the Y steps. One descriptor issues exactly (X+1)·(Y+1) transfers, where X and Y are the stored fields.
- R4: The steps are 12-bit two's-complement byte offsets. After each element that does not end a row, the X step is added to the running address. After a row ends, the next row starts at the previous row's start address plus the Y step.
- R5: Control bits 1:0 set how far one trigger runs: 0 = one element, 1 = one row, 2 = one descriptor, 3 = up to the end of the chain. Under code 3, a linked descriptor starts without any new trigger.
- R6: When control bit 6 is set, an accepted trigger is not followed by another until the trigger input has been seen low. When the bit is clear, a trigger held high keeps retriggering.
- R7: A trigger seen while work is in progress is held in a one-deep pending flag. Further triggers before it is used merge into it.
- R8: Control bits 3:2 select the interrupt event and bits 5:4 select the trigger-out event, using the encoding of R5. Each pulse is high for the one cycle after the transfer handshake that completed the selected event.
- R9: When a descriptor ends with a non-zero link word, the block fetches the descriptor at that address. A zero link word ends the chain.
- R10: When a descriptor ends with control bit 7 set, the channel disables itself. When the bit is clear and the link word is zero, the block fetches the head descriptor again and stays enabled.
- R11: While a transfer request is stalled, the request, both addresses and the size fields stay unchanged. The size field comes from control bits 9:8 (0 byte, 1 halfword, 2 word). The source and destination width flags come from control bits 10 and 11.
- R12: While a read request is stalled, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set_i | input | 1 | Enable pulse; takes `head_ptr_i` when the channel is off |
| head_ptr_i | input | AW | Address of the first descriptor |
| enabled_o | output | 1 | Channel enabled |
| trig_i | input | 1 | Input trigger (level) |
| rd_valid_o | output | 1 | Descriptor read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Descriptor word address |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 32 | Read data |
| xfer_valid_o | output | 1 | Element transfer request valid |
| xfer_ready_i | input | 1 | Element transfer accepted |
| xfer_src_o | output | AW | Source address |
| xfer_dst_o | output | AW | Destination address |
| xfer_size_o | output | 2 | Data size code |
| xfer_src_wide_o | output | 1 | Source transfer width flag |
| xfer_dst_wide_o | output | 1 | Destination transfer width flag |
| irq_o | output | 1 | Interrupt pulse |
| trig_out_o | output | 1 | Output trigger pulse |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 8-bit counts and 12-bit steps. With these widths a link word fills a full address, a step field sits exactly in the upper 24 bits of a loop word, and a negative step makes the address go backward, crossing below the row's starting base. The descriptors keep their counts small, so every row end, descriptor end and chain end is reached within a few dozen cycles. This lets the trigger granularities, the pending merge and the retrigger wait all be observed at the ports, with both ports stalled or toggling.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  localparam int DESC_WORDS = 6;

  typedef enum logic [1:0] {
    EV_ELEM  = 2'd0,
    EV_ROW   = 2'd1,
    EV_DESC  = 2'd2,
    EV_CHAIN = 2'd3
  } dma2d_ev_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } dma2d_st_e;

  // control word bits 11:0, MSB first
  typedef struct packed {
    logic      dst_wide;
    logic      src_wide;
    logic [1:0] size;
    logic      dis_done;
    logic      rtrig_wait;
    dma2d_ev_e tout_ev;
    dma2d_ev_e irq_ev;
    dma2d_ev_e gran;
  } dma2d_ctl_t;

endpackage

// File: rtl/dma2d_fetch.sv
module dma2d_fetch #(
  parameter int AW = 32,
  parameter int NW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [AW-1:0]       base_i,
  output logic                rd_valid_o,
  input  logic                rd_ready_i,
  output logic [AW-1:0]       rd_addr_o,
  input  logic                rsp_valid_i,
  input  logic [31:0]         rsp_data_i,
  output logic                done_o,
  output logic [NW-1:0][31:0] words_o
);
  localparam int IDXW = (NW > 1) ? $clog2(NW) : 1;

  logic            busy_q, wait_rsp_q;
  logic [IDXW-1:0] idx_q;
  logic [AW-1:0]   base_q;

  assign rd_valid_o = busy_q && !wait_rsp_q;
  assign rd_addr_o  = base_q + AW'({idx_q, 2'b00});
  assign done_o     = busy_q && wait_rsp_q && rsp_valid_i && (idx_q == IDXW'(NW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      wait_rsp_q <= 1'b0;
      idx_q      <= '0;
      base_q     <= '0;
      words_o    <= '0;
    end else if (start_i) begin
      busy_q     <= 1'b1;
      wait_rsp_q <= 1'b0;
      idx_q      <= '0;
      base_q     <= base_i;
    end else if (busy_q) begin
      if (!wait_rsp_q && rd_ready_i) begin
        wait_rsp_q <= 1'b1;
      end else if (wait_rsp_q && rsp_valid_i) begin
        words_o[idx_q] <= rsp_data_i;
        wait_rsp_q     <= 1'b0;
        if (idx_q == IDXW'(NW-1)) busy_q <= 1'b0;
        else                      idx_q  <= idx_q + 1'b1;
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i && !start_i |=> rd_valid_o && $stable(rd_addr_o)); // R12

endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] xcnt_i,
  input  logic [CW-1:0] ycnt_i,
  input  logic [IW-1:0] sx_i,
  input  logic [IW-1:0] dx_i,
  input  logic [IW-1:0] sy_i,
  input  logic [IW-1:0] dy_i,
  input  logic          step_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          row_last_o,
  output logic          desc_last_o
);
  localparam int EXT = AW - IW;

  logic [CW-1:0] xi_q, yi_q;
  logic [AW-1:0] srow_q, drow_q, scur_q, dcur_q;
  logic [AW-1:0] sx_w, dx_w, sy_w, dy_w;

  assign sx_w = {{EXT{sx_i[IW-1]}}, sx_i};
  assign dx_w = {{EXT{dx_i[IW-1]}}, dx_i};
  assign sy_w = {{EXT{sy_i[IW-1]}}, sy_i};
  assign dy_w = {{EXT{dy_i[IW-1]}}, dy_i};

  assign src_o       = scur_q;
  assign dst_o       = dcur_q;
  assign row_last_o  = (xi_q == xcnt_i);
  assign desc_last_o = row_last_o && (yi_q == ycnt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xi_q <= '0; yi_q <= '0;
      srow_q <= '0; drow_q <= '0; scur_q <= '0; dcur_q <= '0;
    end else if (load_i) begin
      xi_q <= '0; yi_q <= '0;
      srow_q <= src_i; scur_q <= src_i;
      drow_q <= dst_i; dcur_q <= dst_i;
    end else if (step_i) begin
      if (row_last_o) begin
        xi_q <= '0;
        if (!desc_last_o) begin
          yi_q   <= yi_q + 1'b1;
          srow_q <= srow_q + sy_w;
          drow_q <= drow_q + dy_w;
          scur_q <= srow_q + sy_w;
          dcur_q <= drow_q + dy_w;
        end
      end else begin
        xi_q   <= xi_q + 1'b1;
        scur_q <= scur_q + sx_w;
        dcur_q <= dcur_q + dx_w;
      end
    end
  end

  AST_X_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    xi_q <= xcnt_i); // R3

  AST_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && row_last_o && !desc_last_o && !load_i |=> (xi_q == '0) && (src_o == srow_q)); // R4

endmodule

// File: rtl/dma2d_trig.sv
module dma2d_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic trig_i,
  input  logic wait_en_i,
  input  logic consume_i,
  output logic pend_o
);
  logic armed_q, pend_q;
  logic ev;

  assign ev     = trig_i && armed_q && !clear_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (ev && wait_en_i)  armed_q <= 1'b0;
      else if (!trig_i)     armed_q <= 1'b1;
      if (clear_i) pend_q <= 1'b0;
      else         pend_q <= (pend_q && !consume_i) || ev;
    end
  end

  AST_PEND_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(trig_i)); // R7

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_set_i,
  input  logic [AW-1:0] head_ptr_i,
  output logic          enabled_o,
  input  logic          trig_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rsp_valid_i,
  input  logic [31:0]   rsp_data_i,
  output logic          xfer_valid_o,
  input  logic          xfer_ready_i,
  output logic [AW-1:0] xfer_src_o,
  output logic [AW-1:0] xfer_dst_o,
  output logic [1:0]    xfer_size_o,
  output logic          xfer_src_wide_o,
  output logic          xfer_dst_wide_o,
  output logic          irq_o,
  output logic          trig_out_o
);
  localparam int SX_LO = CW;
  localparam int DX_LO = CW + IW;

  dma2d_st_e               st_q;
  logic [AW-1:0]           head_q;
  logic                    carry_q;
  logic [DESC_WORDS-1:0][31:0] words;
  dma2d_ctl_t              ctl;
  logic [AW-1:0]           link;
  logic                    fetch_start, fetch_done, pend, consume, hs;
  logic [AW-1:0]           fetch_base;
  logic                    row_last, desc_last;
  logic [3:0]              ev;

  assign ctl  = dma2d_ctl_t'(words[0][11:0]);
  assign link = words[5][AW-1:0];

  assign xfer_valid_o    = (st_q == ST_RUN);
  assign hs              = xfer_valid_o && xfer_ready_i;
  assign xfer_size_o     = ctl.size;
  assign xfer_src_wide_o = ctl.src_wide;
  assign xfer_dst_wide_o = ctl.dst_wide;
  assign consume         = (st_q == ST_WAIT) && pend;

  assign ev[EV_ELEM]  = hs;
  assign ev[EV_ROW]   = hs && row_last;
  assign ev[EV_DESC]  = hs && desc_last;
  assign ev[EV_CHAIN] = hs && desc_last && ((link == '0) || ctl.dis_done);

  always_comb begin
    fetch_start = 1'b0;
    fetch_base  = head_ptr_i;
    if (st_q == ST_OFF && en_set_i) begin
      fetch_start = 1'b1;
    end else if (ev[EV_DESC] && !ctl.dis_done) begin
      fetch_start = 1'b1;
      fetch_base  = (link != '0) ? link : head_q;
    end
  end

  dma2d_fetch #(.AW(AW), .NW(DESC_WORDS)) u_fetch (
    .clk, .rst_n,
    .start_i    (fetch_start),
    .base_i     (fetch_base),
    .rd_valid_o,
    .rd_ready_i,
    .rd_addr_o,
    .rsp_valid_i,
    .rsp_data_i,
    .done_o     (fetch_done),
    .words_o    (words)
  );

  dma2d_agen #(.AW(AW), .CW(CW), .IW(IW)) u_agen (
    .clk, .rst_n,
    .load_i     (fetch_done),
    .src_i      (words[1][AW-1:0]),
    .dst_i      (words[2][AW-1:0]),
    .xcnt_i     (words[3][CW-1:0]),
    .ycnt_i     (words[4][CW-1:0]),
    .sx_i       (words[3][SX_LO+IW-1:SX_LO]),
    .dx_i       (words[3][DX_LO+IW-1:DX_LO]),
    .sy_i       (words[4][SX_LO+IW-1:SX_LO]),
    .dy_i       (words[4][DX_LO+IW-1:DX_LO]),
    .step_i     (hs),
    .src_o      (xfer_src_o),
    .dst_o      (xfer_dst_o),
    .row_last_o (row_last),
    .desc_last_o(desc_last)
  );

  dma2d_trig u_trig (
    .clk, .rst_n,
    .clear_i   (!enabled_o),
    .trig_i,
    .wait_en_i (ctl.rtrig_wait),
    .consume_i (consume),
    .pend_o    (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OFF;
      enabled_o  <= 1'b0;
      head_q     <= '0;
      carry_q    <= 1'b0;
      irq_o      <= 1'b0;
      trig_out_o <= 1'b0;
    end else begin
      irq_o      <= ev[ctl.irq_ev];
      trig_out_o <= ev[ctl.tout_ev];
      unique case (st_q)
        ST_OFF: if (en_set_i) begin
          st_q      <= ST_FETCH;
          enabled_o <= 1'b1;
          head_q    <= head_ptr_i;
          carry_q   <= 1'b0;
        end
        ST_FETCH: if (fetch_done) begin
          st_q    <= carry_q ? ST_RUN : ST_WAIT;
          carry_q <= 1'b0;
        end
        ST_WAIT: if (pend) st_q <= ST_RUN;
        ST_RUN: if (hs) begin
          if (desc_last) begin
            if (ctl.dis_done) begin
              st_q      <= ST_OFF;
              enabled_o <= 1'b0;
            end else begin
              st_q    <= ST_FETCH;
              carry_q <= (ctl.gran == EV_CHAIN) && (link != '0);
            end
          end else if (ev[ctl.gran]) begin
            st_q <= ST_WAIT;
          end
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> !enabled_o && !irq_o && !trig_out_o); // R1

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled_o |-> !xfer_valid_o && !rd_valid_o); // R10

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_src_o)
      && $stable(xfer_dst_o) && $stable(xfer_size_o)); // R11

  AST_IRQ_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(xfer_valid_o && xfer_ready_i)); // R8

  AST_TOUT_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out_o |-> $past(xfer_valid_o && xfer_ready_i)); // R8

endmodule

// File: tb/dma2d_seq_test.sv
module dma2d_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_set_i = 1'b0;
  logic [31:0] head_ptr_i = '0;
  logic        enabled_o;
  logic        trig_i = 1'b0;
  logic        rd_valid_o, rd_ready_i;
  logic [31:0] rd_addr_o;
  logic        rsp_valid_i;
  logic [31:0] rsp_data_i;
  logic        xfer_valid_o, xfer_ready_i;
  logic [31:0] xfer_src_o, xfer_dst_o;
  logic [1:0]  xfer_size_o;
  logic        xfer_src_wide_o, xfer_dst_wide_o, irq_o, trig_out_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma2d_seq uut (.*);

  // memory, sink and monitors
  logic [31:0] mem [0:255];
  int rmode = 0, xmode = 0, cyc = 0;
  bit owe = 1'b0;
  logic [31:0] owe_addr;
  int n_rd = 0, n_x = 0, n_irq = 0, n_tout = 0;
  logic [31:0] lg_rd [0:31];
  logic [31:0] lg_src [0:31];
  logic [31:0] lg_dst [0:31];
  logic [3:0]  lg_sz [0:31];

  initial begin
    rd_ready_i = 1'b0; xfer_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_data_i = '0;
  end

  always @(negedge clk) begin
    cyc++;
    rsp_valid_i = 1'b0;
    if (owe) begin rsp_valid_i = 1'b1; rsp_data_i = mem[owe_addr[9:2]]; owe = 1'b0; end
    rd_ready_i   = (rmode == 0) ? 1'b1 : cyc[0];
    xfer_ready_i = (xmode == 0) ? 1'b1 : (xmode == 1) ? cyc[1] : 1'b0;
    if (rst_n && rd_valid_o && rd_ready_i) begin
      owe = 1'b1; owe_addr = rd_addr_o;
      if (n_rd < 32) lg_rd[n_rd] = rd_addr_o;
      n_rd++;
    end
    if (rst_n && xfer_valid_o && xfer_ready_i) begin
      if (n_x < 32) begin
        lg_src[n_x] = xfer_src_o; lg_dst[n_x] = xfer_dst_o;
        lg_sz[n_x]  = {xfer_dst_wide_o, xfer_src_wide_o, xfer_size_o};
      end
      n_x++;
    end
    if (rst_n && irq_o)      n_irq++;
    if (rst_n && trig_out_o) n_tout++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlw(int gran, int irq, int tout, int wt, int dis,
                                       int sz, int sw, int dw);
    return {20'd0, 1'(dw), 1'(sw), 2'(sz), 1'(dis), 1'(wt), 2'(tout), 2'(irq), 2'(gran)};
  endfunction

  function automatic logic [31:0] loopw(int cm1, int sinc, int dinc);
    return {12'(dinc), 12'(sinc), 8'(cm1)};
  endfunction

  task automatic put_desc(int a, logic [31:0] c, logic [31:0] s, logic [31:0] d,
                          logic [31:0] x, logic [31:0] y, logic [31:0] nx);
    mem[(a>>2)+0] = c; mem[(a>>2)+1] = s; mem[(a>>2)+2] = d;
    mem[(a>>2)+3] = x; mem[(a>>2)+4] = y; mem[(a>>2)+5] = nx;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trig_i = 1'b0; en_set_i = 1'b0; rmode = 0; xmode = 0;
    repeat (3) @(negedge clk);
    n_rd = 0; n_x = 0; n_irq = 0; n_tout = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enable(logic [31:0] p);
    @(negedge clk); head_ptr_i = p; en_set_i = 1'b1;
    @(negedge clk); en_set_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 enabled", enabled_o, 0);
    check("R1 xfer_valid", xfer_valid_o, 0);
    check("R1 rd_valid", rd_valid_o, 0);
    check("R1 pulses", {irq_o, trig_out_o}, 0);
  endtask

  // 2-D walk with a negative destination Y step
  task automatic t_walk2d();
    do_reset(); rmode = 1; xmode = 1;
    put_desc('h40, ctlw(2, 1, 2, 0, 1, 2, 1, 0), 32'h1000, 32'h2000,
             loopw(2, 4, 1), loopw(1, 'h100, -16), 0);
    enable(32'h40);
    repeat (40) @(negedge clk);
    check("R2 read count", n_rd, 6);
    for (int i = 0; i < 6; i++) check("R2 read addr", lg_rd[i], 32'h40 + 4*i);
    check("R5 waits for trigger", n_x, 0);
    pulse_trig();
    repeat (40) @(negedge clk);
    check("R3 transfers", n_x, 6);
    check("R4 src0", lg_src[0], 32'h1000); check("R4 src2", lg_src[2], 32'h1008);
    check("R4 src3", lg_src[3], 32'h1100); check("R4 src5", lg_src[5], 32'h1108);
    check("R4 dst1", lg_dst[1], 32'h2001); check("R4 dst3", lg_dst[3], 32'h1FF0);
    check("R4 dst5", lg_dst[5], 32'h1FF2);
    check("R11 size fields", lg_sz[4], 4'b0110);
    check("R8 irq per row", n_irq, 2);
    check("R8 tout per descriptor", n_tout, 1);
    check("R10 disabled", enabled_o, 0);
  endtask

  // enable while already enabled
  task automatic t_en_ignore();
    do_reset();
    put_desc('h40, ctlw(2, 2, 2, 0, 1, 0, 0, 0), 32'h1000, 32'h2000,
             loopw(0, 0, 0), loopw(0, 0, 0), 0);
    put_desc('h80, ctlw(2, 2, 2, 0, 1, 0, 0, 0), 32'h9000, 32'h9100,
             loopw(0, 0, 0), loopw(0, 0, 0), 0);
    enable(32'h40);
    repeat (20) @(negedge clk);
    enable(32'h80);
    repeat (20) @(negedge clk);
    check("R2 second enable no reads", n_rd, 6);
    pulse_trig();
    repeat (10) @(negedge clk);
    check("R2 ignored enable src", lg_src[0], 32'h1000);
    check("R2 one transfer", n_x, 1);
  endtask

  // element granularity with and without retrigger wait
  task automatic t_retrig();
    do_reset();
    put_desc('h40, ctlw(0, 0, 0, 1, 1, 0, 0, 0), 32'h100, 32'h200,
             loopw(1, 4, 4), loopw(0, 0, 0), 0);
    enable(32'h40);
    repeat (20) @(negedge clk);
    trig_i = 1'b1; repeat (30) @(negedge clk);
    check("R6 held trigger gives one element", n_x, 1);
    check("R5 element granularity waits", enabled_o, 1);
    trig_i = 1'b0; repeat (3) @(negedge clk);
    trig_i = 1'b1; repeat (20) @(negedge clk);
    trig_i = 1'b0;
    check("R6 after release second element", n_x, 2);
    check("R8 irq per element", n_irq, 2);
    do_reset();
    put_desc('h40, ctlw(0, 0, 0, 0, 1, 0, 0, 0), 32'h100, 32'h200,
             loopw(1, 4, 4), loopw(0, 0, 0), 0);
    enable(32'h40);
    repeat (20) @(negedge clk);
    trig_i = 1'b1; repeat (20) @(negedge clk); trig_i = 1'b0;
    check("R6 no wait held trigger repeats", n_x, 2);
    check("R10 off after held trigger", enabled_o, 0);
  endtask

  // one-deep pending trigger
  task automatic t_pending();
    do_reset();
    put_desc('h40, ctlw(0, 0, 0, 0, 1, 0, 0, 0), 32'h100, 32'h200,
             loopw(2, 4, 4), loopw(0, 0, 0), 0);
    enable(32'h40);
    repeat (20) @(negedge clk);
    xmode = 2;
    pulse_trig(); repeat (3) @(negedge clk);
    pulse_trig(); repeat (2) @(negedge clk);
    pulse_trig(); repeat (2) @(negedge clk);
    check("R11 stalled no handshake", n_x, 0);
    xmode = 0; repeat (20) @(negedge clk);
    check("R7 merged triggers", n_x, 2);
    check("R7 still enabled", enabled_o, 1);
    pulse_trig(); repeat (10) @(negedge clk);
    check("R7 third element", n_x, 3);
    check("R10 off at end", enabled_o, 0);
  endtask

  // chaining with chain granularity
  task automatic t_chain();
    do_reset(); rmode = 1; xmode = 1;
    put_desc('h80, ctlw(3, 3, 2, 0, 0, 1, 0, 1), 32'h3000, 32'h4000,
             loopw(1, 4, 4), loopw(0, 0, 0), 32'hC0);
    put_desc('hC0, ctlw(3, 3, 2, 0, 1, 1, 0, 1), 32'h5000, 32'h6000,
             loopw(0, 0, 0), loopw(1, 8, -4), 0);
    enable(32'h80);
    repeat (40) @(negedge clk);
    pulse_trig();
    repeat (80) @(negedge clk);
    check("R9 reads both descriptors", n_rd, 12);
    check("R9 link fetch first addr", lg_rd[6], 32'hC0);
    check("R9 link fetch last addr", lg_rd[11], 32'hD4);
    check("R5 chain runs on one trigger", n_x, 4);
    check("R9 src2", lg_src[2], 32'h5000); check("R4 src3", lg_src[3], 32'h5008);
    check("R4 dst3", lg_dst[3], 32'h5FFC);
    check("R8 irq on chain end", n_irq, 1);
    check("R8 tout per descriptor", n_tout, 2);
    check("R10 disabled", enabled_o, 0);
  endtask

  // stay enabled, refetch head
  task automatic t_refetch();
    do_reset();
    put_desc('h100, ctlw(2, 0, 3, 0, 0, 0, 0, 0), 32'h7000, 32'h7100,
             loopw(0, 0, 0), loopw(0, 0, 0), 0);
    enable(32'h100);
    repeat (20) @(negedge clk);
    pulse_trig(); repeat (20) @(negedge clk);
    check("R10 stays enabled", enabled_o, 1);
    check("R10 head refetched", n_rd, 12);
    check("R10 refetch addr", lg_rd[6], 32'h100);
    pulse_trig(); repeat (20) @(negedge clk);
    check("R10 repeat transfers", n_x, 2);
    check("R10 repeat src", lg_src[1], 32'h7000);
    check("R8 irq element count", n_irq, 2);
    check("R8 tout chain count", n_tout, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    t_reset();
    t_walk2d();
    t_en_ignore();
    t_retrig();
    t_pending();
    t_chain();
    t_refetch();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule